// File: doc/BRIEF.md
# Serial Bus Memory Read Front End

This block is the slave side of a two-wire serial bus (I2C) for a 256-byte read-only array. It recognises two 7-bit device identifiers. One selects the memory array. The other selects a space of control and potentiometer registers, whose contents are out of scope. The block keeps an 8-bit address pointer and can serve the memory in three ways:

- **Random read:** a dummy write loads the pointer, then a repeated START opens the read.
- **Current-address read:** the read starts at the pointer.
- **Sequential read:** the read goes on for as many bytes as the master acknowledges.

If a STOP follows the address byte, the pointer is set and the block goes to standby.

Any access to the control space locks out the pointer-based reads. Until a random read to memory has been accepted, only a random read is answered. The data line is open-drain. The block only asserts a pull-down enable. It samples both lines with its own clock and changes that enable only while the serial clock is low.

The array content is computed from the address: the two nibbles of the address are swapped, then XORed with a fill constant (default 0x5A).

Top module: `i2c_mem_reader`

## Requirements
- R1: The slave address byte is 7 identifier bits followed by a read/write bit (1 = read), most significant bit first. Identifier 1010111 (memory) and identifier 1010010 (control space) are acknowledged by driving the data line low in the ninth clock. A read of the control space returns 0xFF.
- R2: An identifier that matches neither target is not acknowledged. All later bytes are ignored, with the data line released, until the next START.
- R3: A random read is START, memory address with write, a word-address byte, repeated START, and memory address with read. It returns the array byte at the word address.
- R4: A STOP after an acknowledged word-address byte loads the pointer. A later current-address read returns the byte at that address.
- R5: Each master acknowledge yields the next byte. The pointer advances by one per transferred byte and wraps from 0xFF to 0x00.
- R6: A master not-acknowledge ends the read. The data line stays released through the following STOP.
- R7: After any acknowledged control-space address, a memory read that is not part of a random read is not acknowledged.
- R8: An accepted random read lifts the lock, and current-address reads are acknowledged again.
- R9: The pull-down enable changes only while the serial clock is low, and it is off during every master acknowledge slot.
- R10: The byte at address a is {a[3:0], a[7:4]} XOR 0x5A.
- R11: After reset the pull-down enable is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Serial clock from the master |
| sda_in | input | 1 | Resolved level of the data line |
| sda_oe | output | 1 | Pull the data line low when 1 |

## Verification
The assertions run on every cycle and cover four properties:
- the pull-down enable moves only while the serial clock is low;
- the enable is off whenever the controller is idle, and after every STOP;
- every START restarts address decoding;
- the pointer changes only by a word-address load or by a step of one.

Only the bench scenarios can show the rest:
- the data values;
- the lock that follows a control-space access, and its release by a random read;
- standby after a STOP that follows the address byte;
- wrap of the pointer across a sequential read.

// File: rtl/i2cmr_pkg.sv
`timescale 1ns/1ps
package i2cmr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_DACK, ST_WADDR, ST_WACK, ST_WSKIP, ST_RD, ST_MACK
  } st_e;
endpackage

// File: rtl/i2cmr_line_sync.sv
`timescale 1ns/1ps
module i2cmr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl};
      sda_sh <= {sda_sh[STAGES-2:0], sda};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_q     = scl_sh[STAGES-1];
  assign sda_q     = sda_sh[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_evt = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_evt  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2cmr_array.sv
`timescale 1ns/1ps
module i2cmr_array #(
  parameter int         AW   = 8,
  parameter logic [7:0] FILL = 8'h5A
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    data
);
  localparam int HALF = AW / 2;
  logic [AW-1:0] swapped;

  assign swapped = {addr[HALF-1:0], addr[AW-1:HALF]};
  assign data    = swapped[7:0] ^ FILL;
endmodule

// File: rtl/i2c_mem_reader.sv
`timescale 1ns/1ps
module i2c_mem_reader #(
  parameter logic [6:0] MEM_ID      = 7'b1010111,
  parameter logic [6:0] CTL_ID      = 7'b1010010,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] FILL        = 8'h5A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda_in,
  output logic sda_oe
);
  import i2cmr_pkg::*;

  localparam int BITS = 8;
  localparam int CW   = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BITS);

  logic sda_q, scl_rise, scl_fall, start_evt, stop_evt;
  st_e  st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d, tx_q, tx_d, rom_data, load_byte;
  logic [AW-1:0] ptr_q, ptr_d;
  logic oe_q, oe_d, ctl_q, ctl_d, rd_q, rd_d;
  logic lock_q, lock_d, fresh_q, fresh_d, aset_q, aset_d, mack_q, mack_d;
  logic ptr_ld;

  i2cmr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_in), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cmr_array #(.AW(AW), .FILL(FILL)) u_array (.addr(ptr_q), .data(rom_data));

  assign load_byte = ctl_q ? 8'hFF : rom_data;
  assign ptr_ld = (st_q == ST_WADDR) && scl_fall && (cnt_q == LAST) && !ctl_q
                  && !start_evt && !stop_evt;

  always_comb begin
    st_d = st_q;  cnt_d = cnt_q;  sh_d = sh_q;  tx_d = tx_q;  ptr_d = ptr_q;
    oe_d = oe_q;  ctl_d = ctl_q;  rd_d = rd_q;  lock_d = lock_q;
    fresh_d = fresh_q;  aset_d = aset_q;  mack_d = mack_q;
    if (start_evt) begin
      st_d = ST_DEV;  cnt_d = '0;  oe_d = 1'b0;
      fresh_d = aset_q;  aset_d = 1'b0;
    end else if (stop_evt) begin
      st_d = ST_IDLE;  oe_d = 1'b0;  aset_d = 1'b0;  fresh_d = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: ;
        ST_DEV: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_q};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST) begin
            rd_d = sh_q[0];
            if (sh_q[7:1] == MEM_ID && (!sh_q[0] || !lock_q || fresh_q)) begin
              st_d = ST_DACK;  oe_d = 1'b1;  ctl_d = 1'b0;
              if (sh_q[0]) lock_d = 1'b0;
            end else if (sh_q[7:1] == CTL_ID) begin
              st_d = ST_DACK;  oe_d = 1'b1;  ctl_d = 1'b1;  lock_d = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_DACK: begin
          if (scl_fall) begin
            if (rd_q) begin
              tx_d = load_byte;  oe_d = ~load_byte[7];  cnt_d = 1;  st_d = ST_RD;
            end else begin
              oe_d = 1'b0;  cnt_d = '0;  st_d = ST_WADDR;
            end
          end
        end
        ST_WADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_q};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST) begin
            st_d = ST_WACK;  oe_d = 1'b1;
            if (ptr_ld) begin
              ptr_d  = sh_q[AW-1:0];
              aset_d = 1'b1;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;  cnt_d = '0;  st_d = ST_WSKIP;
          end
        end
        ST_WSKIP: begin
          if (scl_rise) cnt_d = cnt_q + 1'b1;
          else if (scl_fall && cnt_q == LAST) st_d = ST_IDLE;
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == LAST) begin
              oe_d = 1'b0;  st_d = ST_MACK;
              if (!ctl_q) ptr_d = ptr_q + AW'(1);
            end else begin
              oe_d  = ~tx_q[6];
              tx_d  = {tx_q[6:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_d = ~sda_q;
          else if (scl_fall) begin
            if (mack_q) begin
              tx_d = load_byte;  oe_d = ~load_byte[7];  cnt_d = 1;  st_d = ST_RD;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cnt_q <= '0;  sh_q <= '0;  tx_q <= '0;  ptr_q <= '0;
      oe_q <= 1'b0;  ctl_q <= 1'b0;  rd_q <= 1'b0;  lock_q <= 1'b0;
      fresh_q <= 1'b0;  aset_q <= 1'b0;  mack_q <= 1'b0;
    end else begin
      st_q <= st_d;  cnt_q <= cnt_d;  sh_q <= sh_d;  tx_q <= tx_d;  ptr_q <= ptr_d;
      oe_q <= oe_d;  ctl_q <= ctl_d;  rd_q <= rd_d;  lock_q <= lock_d;
      fresh_q <= fresh_d;  aset_q <= aset_d;  mack_q <= mack_d;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/i2cmr_chk.sv
`timescale 1ns/1ps
module i2cmr_chk #(
  parameter int AW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl,
  input logic            sda_oe,
  input i2cmr_pkg::st_e  st,
  input logic [AW-1:0]   ptr,
  input logic            ptr_ld,
  input logic            start_evt,
  input logic            stop_evt
);
  import i2cmr_pkg::*;

  // R9
  oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl);

  // R2
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe && st == ST_IDLE));

  // R1
  start_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_DEV));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr) && !$past(ptr_ld)) |-> (ptr == AW'($past(ptr) + AW'(1))));
endmodule

bind i2c_mem_reader i2cmr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .sda_oe(sda_oe), .st(st_q),
  .ptr(ptr_q), .ptr_ld(ptr_ld), .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/i2c_mem_reader_bench.sv
`timescale 1ns/1ps
module i2c_mem_reader_bench;
  localparam int Q = 10;
  localparam logic [7:0] MEM_W = 8'hAE, MEM_R = 8'hAF;
  localparam logic [7:0] CTL_W = 8'hA4, CTL_R = 8'hA5;

  logic clk, rst_n, scl, sda_m, sda_oe, sda_bus;
  int n_chk, n_fail, oe_viol;
  logic [7:0] ptr_m;
  logic lock_m, done, oe_prev;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_mem_reader u_i2c_mem_reader (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_bus), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl) oe_viol++;
    oe_prev = sda_oe;
  end

  function automatic logic [7:0] exp_data(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic mack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = {b[6:0], sda_bus}; wq(); scl = 1'b0; wq();
    end
    sda_m = ~mack; wq(); scl = 1'b1; wq();
    chk("R9 ack slot released", int'(sda_oe), 0);
    wq(); scl = 1'b0; wq();
  endtask

  task automatic read_run(input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rd_byte(d, i != n - 1);
      chk(tag, d, exp_data(ptr_m));
      ptr_m = ptr_m + 8'd1;
    end
  endtask

  task automatic random_read(input logic [7:0] a, input int n);
    logic ack;
    start_c(); wr_byte(MEM_W, ack); chk("R1 mem id ack", ack, 1);
    wr_byte(a, ack); chk("R3 word addr ack", ack, 1);
    start_c(); wr_byte(MEM_R, ack); chk("R3 random read ack", ack, 1);
    ptr_m = a; lock_m = 1'b0;
    read_run(n, "R3 R5 R10 random data");
    stop_c();
    chk("R6 released after stop", int'(sda_oe), 0);
  endtask

  task automatic cur_read(input int n);
    logic ack;
    start_c(); wr_byte(MEM_R, ack);
    chk("R7 R8 current read ack", ack, int'(!lock_m));
    if (ack) read_run(n, "R4 R5 current data");
    stop_c();
  endtask

  task automatic set_addr(input logic [7:0] a);
    logic ack;
    start_c(); wr_byte(MEM_W, ack); wr_byte(a, ack);
    chk("R4 set address ack", ack, 1);
    stop_c(); ptr_m = a;
  endtask

  task automatic ctl_access(input logic rd);
    logic ack;
    logic [7:0] d;
    start_c();
    if (rd) begin
      wr_byte(CTL_R, ack); chk("R1 ctl read ack", ack, 1);
      rd_byte(d, 1'b0); chk("R1 ctl read data", d, 8'hFF);
    end else begin
      wr_byte(CTL_W, ack); chk("R1 ctl write ack", ack, 1);
      wr_byte(8'h03, ack);
    end
    stop_c(); lock_m = 1'b1;
  endtask

  task automatic bad_id();
    logic ack;
    start_c(); wr_byte(8'h66, ack); chk("R2 unknown id nack", ack, 0);
    wr_byte(MEM_R, ack); chk("R2 ignored until start", ack, 0);
    stop_c();
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; oe_viol = 0; oe_prev = 1'b0;
    ptr_m = '0; lock_m = 1'b0;
    scl = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    void'($urandom(32'h2C5A));
    repeat (5) @(negedge clk);
    chk("R11 reset released", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cur_read(2);
    random_read(8'hFE, 4);
    cur_read(1);
    set_addr(8'h40);
    cur_read(2);
    ctl_access(1'b0);
    cur_read(1);
    set_addr(8'h10);
    cur_read(1);
    random_read(8'h33, 1);
    cur_read(2);
    ctl_access(1'b1);
    cur_read(1);
    bad_id();
    random_read(8'h00, 2);
    for (int i = 0; i < 14; i++) begin
      case ($urandom_range(0, 4))
        0: random_read(8'($urandom_range(0, 255)), $urandom_range(1, 3));
        1: cur_read($urandom_range(1, 3));
        2: set_addr(8'($urandom_range(0, 255)));
        3: ctl_access(1'($urandom_range(0, 1)));
        default: bad_id();
      endcase
    end
    chk("R9 oe moved while scl high", oe_viol, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule